// File: doc/BRIEF.md
# Power-State Controller with Timed Supply Sequencer

This block decides whether a device is off, fully running, or napping. It also turns the supply rails on and off in a fixed, slot-timed order. Three wake sources are combined with OR: a push-button line (active low, debounced), a hold line (active high) and a software on bit. Any one of them powers the device up unless the single fault input is asserted. From OFF, the block ramps the rails on one per time slot. The order comes from one of three built-in sequences chosen by the boot pins. The reset-release output goes high one slot after the last rail is on.

While running, a sleep request moves the block into a nap state. In that state each rail either stays at full load, drops to low-power mode, or is switched off, according to per-rail keep-on and set-off bits. An accepted button press, or removal of the sleep request, wakes the device. The cleared rails are then brought back in the same order, with a slot length chosen separately for waking. When every wake source goes away, the rails are dropped in reverse order. The same power-down happens after a long button hold. A rail handed to an external enable line follows that line and ignores the nap state.

Inputs are taken as synchronous to the clock. Debounce time, long-press time and both slot lengths are parameters in clock cycles.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, sup_en and sup_lp are all zero, rst_out_n is 0 and btn_irq is 0.
- R2: While OFF, the block starts power-up when the debounced button is low, or hold is 1, or sw_on is 1, provided fault is 0. With no source present, or with fault at 1, all rails stay off.
- R3: A change on btn_n is accepted only after it has held its new value for DEB_CYC consecutive cycles. btn_irq pulses for exactly one cycle, in the cycle after an accepted falling edge. A press shorter than DEB_CYC cycles gives no pulse.
- R4: Power-up enables one rail per slot, the first one slot after the start. boot_sel picks the order: 0 gives ascending index, 1 gives descending index, 2 swaps adjacent pairs (1,0,3,2), and 3 behaves as 0.
- R5: A slot lasts SLOT_SHORT_CYC cycles when its select bit is 0 and SLOT_LONG_CYC cycles when it is 1. slot_boot_sel times power-up from OFF and power-down. slot_wake_sel times the ramp out of the nap state.
- R6: rst_out_n goes to 1 one slot after the last rail of a power-up from OFF is enabled.
- R7: When every wake source is gone, rst_out_n falls on the next edge. The rails are then cleared one per slot in the reverse of the power-up order, and the block returns to OFF.
- R8: While running, sleep_req = 1 with the button released enters the nap state on the next edge. A rail with keep_on = 1 stays at full load. Otherwise, set_off = 1 switches the rail off. Otherwise, the rail stays on with sup_lp = 1.
- R9: From the nap state, an accepted button falling edge, or sleep_req = 0, starts a wake ramp. The ramp re-enables the cleared rails in sequence order using the wake slot length, and rst_out_n stays 1 throughout.
- R10: While running or napping, a rail with ext_sel = 1 drives sup_en from ext_en and shows sup_lp = 0.
- R11: When the debounced button has been low for LONG_CYC cycles, power-down starts regardless of the other sources. The device stays off for as long as the button is held.
- R12: With fault = 1, the next edge puts the block in OFF with every rail disabled and rst_out_n at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_n | input | 1 | Push-button line, low when pressed |
| hold | input | 1 | Hold request, active high |
| sw_on | input | 1 | Software device-on bit |
| sleep_req | input | 1 | Nap request |
| fault | input | 1 | Combined disable condition |
| boot_sel | input | 2 | Built-in sequence select |
| slot_boot_sel | input | 1 | Slot length for power-up from OFF and for power-down |
| slot_wake_sel | input | 1 | Slot length for the wake ramp |
| keep_on | input | N_SUP | Per-rail keep full load in nap |
| set_off | input | N_SUP | Per-rail switch off in nap |
| ext_sel | input | N_SUP | Per-rail hand-over to external enable |
| ext_en | input | N_SUP | External enable values |
| sup_en | output | N_SUP | Rail enables |
| sup_lp | output | N_SUP | Rail low-power flags |
| rst_out_n | output | 1 | Reset release, active low |
| btn_irq | output | 1 | One-cycle accepted-press pulse |

## Verification
A vector table drives each wake source on its own, with no source present, and with fault combined with the sources. This shows that the OR of the sources is gated by fault. Power-up is traced slot by slot for every boot code and for both slot lengths, which separates the orderings from one another and the short timing from the long. Power-down from the descending sequence shows that the reverse order comes from the sequence itself and not from index order. Nap patterns mix the keep, off and low-power outcomes, including one rail with both bits set. Button stimuli separate a short glitch, an accepted press that wakes the device, and a hold long enough to force the device off.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_OFF,
    PM_RAMP,
    PM_ON,
    PM_NAP,
    PM_DRAIN
  } pm_state_e;

  // Rail index enabled at a given step of the chosen built-in sequence.
  function automatic int seq_pick(input logic [1:0] mode, input int step, input int n);
    int alt;
    alt = step ^ 1;
    case (mode)
      2'd1:    return n - 1 - step;
      2'd2:    return (alt < n) ? alt : step;
      default: return step;
    endcase
  endfunction

  // Last count value of a slot for the selected length.
  function automatic int slot_last(input logic long_sel, input int short_c, input int long_c);
    return (long_sel ? long_c : short_c) - 1;
  endfunction

endpackage

// File: rtl/pm_button_filter.sv
module pm_button_filter #(
  parameter int DEB_CYC  = 4,
  parameter int LONG_CYC = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic btn_lvl,
  output logic btn_fall,
  output logic long_hit
);
  localparam int DW = $clog2(DEB_CYC + 1);
  localparam int LW = $clog2(LONG_CYC + 1);

  logic          lvl_q;
  logic [DW-1:0] dcnt_q;
  logic [LW-1:0] lcnt_q;
  logic          accept;

  assign accept   = (btn_n != lvl_q) && (dcnt_q == DW'(DEB_CYC - 1));
  assign btn_fall = accept && lvl_q;
  assign long_hit = !lvl_q && (lcnt_q == LW'(LONG_CYC - 1));
  assign btn_lvl  = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      dcnt_q <= '0;
    end else if (btn_n == lvl_q) begin
      dcnt_q <= '0;
    end else if (accept) begin
      lvl_q  <= btn_n;
      dcnt_q <= '0;
    end else begin
      dcnt_q <= dcnt_q + 1'b1;
    end
  end

  // Counts how long the accepted level has been low, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         lcnt_q <= '0;
    else if (lvl_q)                     lcnt_q <= '0;
    else if (lcnt_q != LW'(LONG_CYC))   lcnt_q <= lcnt_q + 1'b1;
  end
endmodule

// File: rtl/pm_slot_timer.sv
module pm_slot_timer
  import pwr_mode_pkg::*;
#(
  parameter int SLOT_SHORT_CYC = 3,
  parameter int SLOT_LONG_CYC  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic len_sel,
  output logic tick
);
  localparam int MAXC = (SLOT_LONG_CYC > SLOT_SHORT_CYC) ? SLOT_LONG_CYC : SLOT_SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = CW'(slot_last(len_sel, SLOT_SHORT_CYC, SLOT_LONG_CYC));
  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pm_supply_gate.sv
module pm_supply_gate #(
  parameter int N_SUP = 4
) (
  input  logic             live,
  input  logic             nap,
  input  logic [N_SUP-1:0] en_q,
  input  logic [N_SUP-1:0] keep_on,
  input  logic [N_SUP-1:0] ext_sel,
  input  logic [N_SUP-1:0] ext_en,
  output logic [N_SUP-1:0] sup_en,
  output logic [N_SUP-1:0] sup_lp
);
  for (genvar i = 0; i < N_SUP; i++) begin : g_rail
    logic handed;
    assign handed    = live && ext_sel[i];
    assign sup_en[i] = handed ? ext_en[i] : en_q[i];
    assign sup_lp[i] = nap && en_q[i] && !keep_on[i] && !ext_sel[i];
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_SUP          = 4,
  parameter int DEB_CYC        = 4,
  parameter int LONG_CYC       = 60,
  parameter int SLOT_SHORT_CYC = 3,
  parameter int SLOT_LONG_CYC  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_n,
  input  logic             hold,
  input  logic             sw_on,
  input  logic             sleep_req,
  input  logic             fault,
  input  logic [1:0]       boot_sel,
  input  logic             slot_boot_sel,
  input  logic             slot_wake_sel,
  input  logic [N_SUP-1:0] keep_on,
  input  logic [N_SUP-1:0] set_off,
  input  logic [N_SUP-1:0] ext_sel,
  input  logic [N_SUP-1:0] ext_en,
  output logic [N_SUP-1:0] sup_en,
  output logic [N_SUP-1:0] sup_lp,
  output logic             rst_out_n,
  output logic             btn_irq
);
  localparam int SW = $clog2(N_SUP + 1);
  localparam int IW = (N_SUP > 1) ? $clog2(N_SUP) : 1;
  localparam logic [SW-1:0] STEP_END = SW'(N_SUP);

  pm_state_e      st_q;
  logic [N_SUP-1:0] en_q;
  logic [SW-1:0]  step_q;
  logic [1:0]     boot_q;
  logic           wake_q, rst_q, irq_q, force_q;

  logic btn_lvl, btn_fall, long_hit, tick, on_req;
  logic go_drain, go_nap, go_wake;
  logic in_ramp, nap_entry;
  logic [IW-1:0] pick_up, pick_dn;

  pm_button_filter #(.DEB_CYC(DEB_CYC), .LONG_CYC(LONG_CYC)) u_btn (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
    .btn_lvl(btn_lvl), .btn_fall(btn_fall), .long_hit(long_hit)
  );

  pm_slot_timer #(.SLOT_SHORT_CYC(SLOT_SHORT_CYC), .SLOT_LONG_CYC(SLOT_LONG_CYC)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .run(st_q == PM_RAMP || st_q == PM_DRAIN),
    .len_sel(wake_q ? slot_wake_sel : slot_boot_sel),
    .tick(tick)
  );

  pm_supply_gate #(.N_SUP(N_SUP)) u_gate (
    .live(st_q == PM_ON || st_q == PM_NAP), .nap(st_q == PM_NAP),
    .en_q(en_q), .keep_on(keep_on), .ext_sel(ext_sel), .ext_en(ext_en),
    .sup_en(sup_en), .sup_lp(sup_lp)
  );

  // Internal events, named so the checker can watch them.
  assign on_req    = (!btn_lvl || hold || sw_on) && !force_q;
  assign go_drain  = long_hit || !on_req;
  assign go_nap    = sleep_req && btn_lvl;
  assign go_wake   = btn_fall || !sleep_req;
  assign in_ramp   = (st_q == PM_RAMP);
  assign nap_entry = (st_q == PM_ON) && !fault && !go_drain && go_nap;

  assign pick_up = IW'(seq_pick(boot_q, int'(step_q), N_SUP));
  assign pick_dn = IW'(seq_pick(boot_q, int'(step_q) - 1, N_SUP));

  assign rst_out_n = rst_q;
  assign btn_irq   = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      force_q <= 1'b0;
    end else begin
      irq_q <= btn_fall;
      if (long_hit)     force_q <= 1'b1;
      else if (btn_lvl) force_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PM_OFF;
      en_q   <= '0;
      step_q <= '0;
      boot_q <= '0;
      wake_q <= 1'b0;
      rst_q  <= 1'b0;
    end else if (fault) begin
      st_q   <= PM_OFF;
      en_q   <= '0;
      step_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      case (st_q)
        PM_OFF: if (on_req) begin
          st_q   <= PM_RAMP;
          step_q <= '0;
          boot_q <= boot_sel;
          wake_q <= 1'b0;
        end
        PM_RAMP: if (tick) begin
          if (step_q != STEP_END) begin
            en_q[pick_up] <= 1'b1;
            step_q        <= step_q + 1'b1;
          end else begin
            st_q  <= PM_ON;
            rst_q <= 1'b1;
          end
        end
        PM_ON: if (go_drain) begin
          st_q   <= PM_DRAIN;
          rst_q  <= 1'b0;
          step_q <= STEP_END;
          wake_q <= 1'b0;
        end else if (go_nap) begin
          st_q <= PM_NAP;
          en_q <= en_q & ~(set_off & ~keep_on & ~ext_sel);
        end
        PM_NAP: if (go_drain) begin
          st_q   <= PM_DRAIN;
          rst_q  <= 1'b0;
          step_q <= STEP_END;
          wake_q <= 1'b0;
        end else if (go_wake) begin
          st_q   <= PM_RAMP;
          step_q <= '0;
          wake_q <= 1'b1;
        end
        PM_DRAIN: if (tick) begin
          if (step_q != '0) begin
            en_q[pick_dn] <= 1'b0;
            step_q        <= step_q - 1'b1;
          end else begin
            st_q <= PM_OFF;
          end
        end
        default: st_q <= PM_OFF;
      endcase
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int N_SUP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fault,
  input logic             btn_irq,
  input logic             rst_out_n,
  input logic [N_SUP-1:0] sup_en,
  input logic [N_SUP-1:0] sup_lp,
  input logic [N_SUP-1:0] en_q,
  input logic             in_ramp,
  input logic             nap_entry
);
  assert_fault_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (en_q == '0 && !rst_out_n));

  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    btn_irq |=> !btn_irq);

  assert_ramp_only_adds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ramp && !fault) |=> ((en_q & $past(en_q)) == $past(en_q)));

  assert_one_rail_per_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !nap_entry) |=> $onehot0(en_q ^ $past(en_q)));

  assert_lp_only_when_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_lp & ~sup_en) == '0);

  assert_release_all_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> (&en_q));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_SUP(N_SUP)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault(fault), .btn_irq(btn_irq),
  .rst_out_n(rst_out_n), .sup_en(sup_en), .sup_lp(sup_lp),
  .en_q(en_q), .in_ramp(in_ramp), .nap_entry(nap_entry)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int PERIOD = 10;
  localparam int N      = 4;
  localparam int DEB    = 4;
  localparam int LONGP  = 60;
  localparam int SS     = 3;
  localparam int SL     = 8;

  logic clk = 0, rst_n = 0;
  logic btn_n, hold, sw_on, sleep_req, fault, slot_boot_sel, slot_wake_sel;
  logic [1:0] boot_sel;
  logic [N-1:0] keep_on, set_off, ext_sel, ext_en, sup_en, sup_lp;
  logic rst_out_n, btn_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.N_SUP(N), .DEB_CYC(DEB), .LONG_CYC(LONGP),
                  .SLOT_SHORT_CYC(SS), .SLOT_LONG_CYC(SL)) uut (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .hold(hold), .sw_on(sw_on),
    .sleep_req(sleep_req), .fault(fault), .boot_sel(boot_sel),
    .slot_boot_sel(slot_boot_sel), .slot_wake_sel(slot_wake_sel),
    .keep_on(keep_on), .set_off(set_off), .ext_sel(ext_sel), .ext_en(ext_en),
    .sup_en(sup_en), .sup_lp(sup_lp), .rst_out_n(rst_out_n), .btn_irq(btn_irq)
  );

  // Bit fields of a vector: [4] btn_n, [3] hold, [2] sw_on, [1] fault, [0] expect on.
  localparam logic [4:0] VEC [0:5] = '{5'b10000, 5'b00001, 5'b11001,
                                        5'b10101, 5'b11110, 5'b01110};

  function automatic int exp_order(input int boot, input int k);
    int swapped [4] = '{1, 0, 3, 2};
    if (boot == 1) return N - 1 - k;
    if (boot == 2) return swapped[k];
    return k;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; btn_n = 1; hold = 0; sw_on = 0; sleep_req = 0; fault = 0;
    boot_sel = 0; slot_boot_sel = 0; slot_wake_sel = 0;
    keep_on = 0; set_off = 0; ext_sel = 0; ext_en = 0;
    wait_cyc(3);
    rst_n = 1;
  endtask

  task automatic ramp_check(input int boot, input bit lng, input string tag);
    int slot = lng ? SL : SS;
    logic [N-1:0] m = '0;
    do_reset();
    boot_sel = 2'(boot); slot_boot_sel = lng;
    hold = 1;
    wait_cyc(slot);
    chk(sup_en == 0, {tag, " R5 before first slot"}, sup_en, 0);
    wait_cyc(1);
    m[exp_order(boot, 0)] = 1'b1;
    chk(sup_en == m, {tag, " R4 first rail"}, sup_en, m);
    for (int k = 1; k < N; k++) begin
      wait_cyc(slot);
      m[exp_order(boot, k)] = 1'b1;
      chk(sup_en == m, {tag, " R4 next rail"}, sup_en, m);
    end
    wait_cyc(slot - 1);
    chk(rst_out_n == 0, {tag, " R6 release not early"}, rst_out_n, 0);
    wait_cyc(1);
    chk(rst_out_n == 1, {tag, " R6 release"}, rst_out_n, 1);
  endtask

  initial begin
    logic [N-1:0] m;
    do_reset();
    // R1 reset state
    chk(sup_en == 0 && sup_lp == 0, "R1 rails", {sup_en, sup_lp}, 0);
    chk(rst_out_n == 0 && btn_irq == 0, "R1 reset/irq", {rst_out_n, btn_irq}, 0);

    // R2 source table
    for (int v = 0; v < 6; v++) begin
      do_reset();
      {btn_n, hold, sw_on, fault} = VEC[v][4:1];
      wait_cyc(40);
      if (VEC[v][0])
        chk(sup_en == 4'hF && rst_out_n, "R2 source on", {sup_en, rst_out_n}, 5'h1F);
      else
        chk(sup_en == 0 && !rst_out_n, "R2 source off", {sup_en, rst_out_n}, 0);
    end

    // R4/R5/R6 orderings and slot lengths
    ramp_check(0, 0, "boot0");
    ramp_check(2, 0, "boot2");
    ramp_check(3, 0, "boot3");
    ramp_check(0, 1, "boot0 long");
    ramp_check(1, 0, "boot1");

    // R7 reverse power-down (still running boot1 from above)
    hold = 0;
    wait_cyc(1);
    chk(rst_out_n == 0 && sup_en == 4'hF, "R7 release drops first", {sup_en, rst_out_n}, 5'h1E);
    m = 4'hF;
    for (int k = 1; k <= N; k++) begin
      wait_cyc(SS);
      m[exp_order(1, N - k)] = 1'b0;
      chk(sup_en == m, "R7 reverse clear", sup_en, m);
    end
    wait_cyc(20);
    chk(sup_en == 0 && rst_out_n == 0, "R7 stays off", {sup_en, rst_out_n}, 0);

    // R8 nap entry
    do_reset();
    hold = 1; keep_on = 4'b0011; set_off = 4'b0110;
    wait_cyc(30);
    sleep_req = 1;
    wait_cyc(1);
    chk(sup_en == 4'b1011, "R8 nap enables", sup_en, 4'b1011);
    chk(sup_lp == 4'b1000, "R8 nap low-power", sup_lp, 4'b1000);

    // R10 external control
    ext_sel = 4'b1000; ext_en = 4'b0000;
    wait_cyc(1);
    chk(sup_en == 4'b0011 && sup_lp == 0, "R10 ext low", {sup_en, sup_lp}, 8'h30);
    ext_en = 4'b1000;
    wait_cyc(1);
    chk(sup_en == 4'b1011, "R10 ext high", sup_en, 4'b1011);
    ext_sel = 0; ext_en = 0;

    // R3/R9 button wake with long wake slots
    slot_wake_sel = 1;
    btn_n = 0;
    wait_cyc(DEB - 1);
    chk(btn_irq == 0, "R3 not yet accepted", btn_irq, 0);
    wait_cyc(1);
    chk(btn_irq == 1, "R3 irq pulse", btn_irq, 1);
    wait_cyc(1);
    chk(btn_irq == 0 && rst_out_n == 1, "R3/R9 pulse ends, release held", {btn_irq, rst_out_n}, 1);
    wait_cyc(3 * SL - 2);
    chk(sup_en == 4'b1011, "R9 wake slot timing", sup_en, 4'b1011);
    wait_cyc(1);
    chk(sup_en == 4'hF, "R9 rail restored", sup_en, 4'hF);
    btn_n = 1;
    wait_cyc(20);
    chk(sup_en == 4'b1011 && sup_lp == 4'b1000, "R8 re-nap", {sup_en, sup_lp}, 8'hB8);

    // R9 wake by dropping the request
    sleep_req = 0;
    wait_cyc(45);
    chk(sup_en == 4'hF && sup_lp == 0 && rst_out_n, "R9 request wake", {sup_en, sup_lp, rst_out_n}, 9'h1E1);

    // R3 glitch shorter than debounce
    btn_n = 0;
    wait_cyc(DEB - 1);
    btn_n = 1;
    for (int k = 0; k < DEB + 3; k++) begin
      chk(btn_irq == 0, "R3 glitch ignored", btn_irq, 0);
      wait_cyc(1);
    end

    // R11 long press
    btn_n = 0;
    wait_cyc(DEB + LONGP - 1);
    chk(rst_out_n == 1, "R11 before long time", rst_out_n, 1);
    wait_cyc(1);
    chk(rst_out_n == 0, "R11 forced down", rst_out_n, 0);
    wait_cyc(30);
    chk(sup_en == 0, "R11 held off", sup_en, 0);
    btn_n = 1;
    wait_cyc(40);
    chk(rst_out_n == 1, "R2 hold restarts after release", rst_out_n, 1);

    // R12 fault
    fault = 1;
    wait_cyc(1);
    chk(sup_en == 0 && rst_out_n == 0, "R12 fault off", {sup_en, rst_out_n}, 0);
    wait_cyc(10);
    chk(sup_en == 0, "R12 fault holds off", sup_en, 0);
    fault = 0;
    wait_cyc(40);
    chk(sup_en == 4'hF, "R12 recovers", sup_en, 4'hF);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule